// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block performs the state update that a 32-bit RISC core makes when it takes a synchronous exception or accepts an external or timer interrupt. Each cycle it looks at a synchronous exception request and at two interrupt lines, picks at most one cause, and on the next clock edge commits every register update at once. The committed values are the exception return address, the fault address, the saved and new status words, the power-management word, an invalidated load-link reservation and the new fetch address.

The core supplies its current PC, status word, power-management word, delay-slot flag, vector-base register and configuration word. On every entry the block raises a one-cycle taken pulse that carries the selected cause code. A request that carries an undefined cause code raises a one-cycle error pulse instead, and no register changes. All output registers hold their values between entries.

Top module: `exc_entry_ctrl`

## Requirements
- R1: On entry, the return address `epc_o` is the current PC. For a system call (code 12) it is the current PC plus 4.
- R2: If `dslot_i` is high on entry, `epc_o` is reduced by 4, status bit 13 (delay-slot exception) of `sr_o` is set, and `dslot_clr_o` pulses. If `dslot_i` is low, bit 13 is cleared and `dslot_clr_o` stays low.
- R3: `eear_o` loads the current PC only on an illegal-instruction entry (code 7). Any other entry leaves it unchanged.
- R4: On entry, `esr_o` captures `sr_i`. `sr_o` is `sr_i` with bits 6 (instruction MMU), 5 (data MMU), 2 (interrupt enable) and 1 (tick enable) cleared and bit 0 (supervisor) set.
- R5: On entry, `pmr_o` is `pmr_i` with bits 4 (doze) and 5 (sleep) cleared, and `lladdr_o` becomes all ones.
- R6: The new fetch address is the cause code shifted left by 8. `evbar_i` is ORed in when bit 9 of `cfg_i` is set, and 0xF0000000 is ORed in when bit 14 (high exception prefix) of `sr_i` is set.
- R7: A request whose code is 0 or above 14 raises `err_o` for one cycle, raises no taken pulse, and changes no output register.
- R8: The device interrupt (code 8) is accepted only while `sr_i` bit 2 is set. The tick interrupt (code 5) is accepted only while `sr_i` bit 1 is set. When both are pending and enabled, the tick interrupt is taken.
- R9: A synchronous request with a valid code wins over both interrupt lines in the same cycle.
- R10: `taken_o` is a one-cycle pulse, and `code_o` shows the selected code during it and 0 otherwise. When nothing is taken, every output register holds its value.
- R11: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | 32 | Current PC |
| sr_i | input | 32 | Current status word |
| pmr_i | input | 32 | Current power-management word |
| dslot_i | input | 1 | Current instruction sits in a delay slot |
| evbar_i | input | 32 | Vector base |
| cfg_i | input | 32 | Configuration word; bit 9 means the vector base is present |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_code_i | input | 4 | Cause code of the request |
| dev_irq_i | input | 1 | Device interrupt pending |
| tick_irq_i | input | 1 | Tick timer interrupt pending |
| taken_o | output | 1 | Entry committed this cycle |
| code_o | output | 4 | Code of the committed entry, 0 when idle |
| err_o | output | 1 | Undefined cause code was rejected |
| dslot_clr_o | output | 1 | Delay-slot flag must be cleared |
| epc_o | output | 32 | Exception return address |
| eear_o | output | 32 | Effective-address register |
| esr_o | output | 32 | Saved status |
| sr_o | output | 32 | New status |
| pmr_o | output | 32 | New power-management word |
| lladdr_o | output | 32 | Load-link reservation address |
| fetch_pc_o | output | 32 | New fetch address |

## Verification
The assertions assume that every input is stable and known at each clock edge, and that the two interrupt lines are only meaningful while no valid synchronous request is present. The stimulus changes inputs only at the falling edge. It draws codes from the full 4-bit range, so undefined codes show up often. It randomises status enables, the delay-slot flag, the prefix bit and the base-present bit. Directed cycles add the overlaps: both interrupts pending at once, a request together with interrupts, and a system call in a delay slot.

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl #(
  parameter int XLEN       = 32,
  parameter int CODE_W     = 4,
  parameter int NUM_CAUSES = 14,
  parameter int VEC_SHIFT  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   sr_i,
  input  logic [XLEN-1:0]   pmr_i,
  input  logic              dslot_i,
  input  logic [XLEN-1:0]   evbar_i,
  input  logic [XLEN-1:0]   cfg_i,
  input  logic              exc_req_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              dev_irq_i,
  input  logic              tick_irq_i,
  output logic              taken_o,
  output logic [CODE_W-1:0] code_o,
  output logic              err_o,
  output logic              dslot_clr_o,
  output logic [XLEN-1:0]   epc_o,
  output logic [XLEN-1:0]   eear_o,
  output logic [XLEN-1:0]   esr_o,
  output logic [XLEN-1:0]   sr_o,
  output logic [XLEN-1:0]   pmr_o,
  output logic [XLEN-1:0]   lladdr_o,
  output logic [XLEN-1:0]   fetch_pc_o
);
  localparam int SR_SM = 0, SR_TEE = 1, SR_IEE = 2, SR_DME = 5, SR_IME = 6;
  localparam int SR_DSX = 13, SR_EPH = 14;
  localparam int PM_DOZE = 4, PM_SLEEP = 5;
  localparam int CFG_VBASE = 9;
  localparam logic [CODE_W-1:0] C_TICK = CODE_W'(5);
  localparam logic [CODE_W-1:0] C_ILL  = CODE_W'(7);
  localparam logic [CODE_W-1:0] C_DEV  = CODE_W'(8);
  localparam logic [CODE_W-1:0] C_SYS  = CODE_W'(12);
  localparam logic [XLEN-1:0]   STEP   = XLEN'(4);
  localparam logic [XLEN-1:0]   HI_REGION = {4'hF, {(XLEN-4){1'b0}}};
  localparam logic [XLEN-1:0]   SR_OFF = (XLEN'(1) << SR_DME) | (XLEN'(1) << SR_IME)
                                       | (XLEN'(1) << SR_IEE) | (XLEN'(1) << SR_TEE)
                                       | (XLEN'(1) << SR_DSX);
  localparam logic [XLEN-1:0]   PM_OFF = (XLEN'(1) << PM_DOZE) | (XLEN'(1) << PM_SLEEP);

  logic              take, bad;
  logic [CODE_W-1:0] sel;

  wire code_ok = (exc_code_i != '0) && (exc_code_i <= CODE_W'(NUM_CAUSES));

  always_comb begin
    take = 1'b0;
    bad  = 1'b0;
    sel  = '0;
    if (exc_req_i) begin
      take = code_ok;
      bad  = !code_ok;
      sel  = code_ok ? exc_code_i : '0;
    end else if (tick_irq_i && sr_i[SR_TEE]) begin
      take = 1'b1;
      sel  = C_TICK;
    end else if (dev_irq_i && sr_i[SR_IEE]) begin
      take = 1'b1;
      sel  = C_DEV;
    end
  end

  wire [XLEN-1:0] epc_nxt = pc_i + ((sel == C_SYS) ? STEP : '0) - (dslot_i ? STEP : '0);
  wire [XLEN-1:0] vec_nxt = (XLEN'(sel) << VEC_SHIFT)
                          | (cfg_i[CFG_VBASE] ? evbar_i : '0)
                          | (sr_i[SR_EPH] ? HI_REGION : '0);
  wire [XLEN-1:0] sr_nxt  = (sr_i & ~SR_OFF) | (XLEN'(1) << SR_SM)
                          | (XLEN'(dslot_i) << SR_DSX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taken_o <= 1'b0; code_o <= '0; err_o <= 1'b0; dslot_clr_o <= 1'b0;
      epc_o <= '0; eear_o <= '0; esr_o <= '0; sr_o <= '0;
      pmr_o <= '0; lladdr_o <= '0; fetch_pc_o <= '0;
    end else begin
      taken_o     <= take;
      code_o      <= sel;
      err_o       <= bad;
      dslot_clr_o <= take && dslot_i;
      if (take) begin
        epc_o      <= epc_nxt;
        esr_o      <= sr_i;
        sr_o       <= sr_nxt;
        pmr_o      <= pmr_i & ~PM_OFF;
        lladdr_o   <= '1;
        fetch_pc_o <= vec_nxt;
        if (sel == C_ILL) eear_o <= pc_i;
      end
    end
  end

  AST_TAKE_XOR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !(taken_o && err_o)); // R7
  AST_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req_i && !code_ok) |=> (err_o && !taken_o && $stable(fetch_pc_o) && $stable(epc_o))); // R7
  AST_SR_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> (sr_o[SR_SM] && !sr_o[SR_IEE] && !sr_o[SR_TEE] && !sr_o[SR_DME] && !sr_o[SR_IME])); // R4
  AST_LL_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> (lladdr_o == '1 && !pmr_o[PM_DOZE] && !pmr_o[PM_SLEEP])); // R5
  AST_TICK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_req_i && tick_irq_i && sr_i[SR_TEE]) |=> (taken_o && code_o == C_TICK)); // R8
  AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req_i && code_ok) |=> (taken_o && code_o == $past(exc_code_i))); // R9
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !taken_o |-> code_o == '0); // R10
  AST_EEAR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_o && code_o != C_ILL) |-> $stable(eear_o)); // R3
  AST_DSX_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> (sr_o[SR_DSX] == dslot_clr_o)); // R2
endmodule

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic [31:0] pc, sr, pmr, evbar, cfg;
  logic dslot, req, dev, tick;
  logic [3:0] code;
  logic taken, err, dclr;
  logic [3:0] code_q;
  logic [31:0] epc, eear, esr, sro, pmro, lla, fpc;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_epc, m_eear, m_esr, m_sr, m_pmr, m_lla, m_fpc;
  logic m_taken, m_err, m_dclr;
  logic [3:0] m_code;

  always #4 clk = ~clk;

  exc_entry_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pc_i(pc), .sr_i(sr), .pmr_i(pmr), .dslot_i(dslot),
    .evbar_i(evbar), .cfg_i(cfg), .exc_req_i(req), .exc_code_i(code),
    .dev_irq_i(dev), .tick_irq_i(tick), .taken_o(taken), .code_o(code_q),
    .err_o(err), .dslot_clr_o(dclr), .epc_o(epc), .eear_o(eear), .esr_o(esr),
    .sr_o(sro), .pmr_o(pmro), .lladdr_o(lla), .fetch_pc_o(fpc));

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  function automatic logic [3:0] pick(output logic bad);
    bad = 0;
    if (req) begin
      if (code == 0 || code > 14) begin bad = 1; return 0; end
      return code;
    end
    if (tick && sr[1]) return 4'd5;   // R8
    if (dev && sr[2]) return 4'd8;
    return 0;
  endfunction

  task automatic step();
    logic bad; logic [3:0] s;
    s = pick(bad);
    @(posedge clk); #1;
    m_taken = (s != 0); m_err = bad; m_code = s; m_dclr = m_taken && dslot;
    if (m_taken) begin
      m_epc = pc + (s == 12 ? 32'd4 : 32'd0) - (dslot ? 32'd4 : 32'd0);
      if (s == 7) m_eear = pc;
      m_esr = sr;
      m_sr = (sr & ~32'h0000_2066) | 32'h1 | (dslot ? 32'h2000 : 32'h0);
      m_pmr = pmr & ~32'h30;
      m_lla = '1;
      m_fpc = ({28'd0, s} << 8) | (cfg[9] ? evbar : 32'h0) | (sr[14] ? 32'hF000_0000 : 32'h0);
    end
    chk("R10 taken", {31'd0, taken}, {31'd0, m_taken});
    chk("R10 code", {28'd0, code_q}, {28'd0, m_code});
    chk("R7 err", {31'd0, err}, {31'd0, m_err});
    chk("R2 dslot_clr", {31'd0, dclr}, {31'd0, m_dclr});
    chk("R1 epc", epc, m_epc);
    chk("R3 eear", eear, m_eear);
    chk("R4 esr", esr, m_esr);
    chk("R4 sr", sro, m_sr);
    chk("R5 pmr", pmro, m_pmr);
    chk("R5 lladdr", lla, m_lla);
    chk("R6 fetch", fpc, m_fpc);
    @(negedge clk);
  endtask

  task automatic drive(logic r, logic [3:0] c, logic d, logic t, logic [31:0] s, logic ds);
    req = r; code = c; dev = d; tick = t; sr = s; dslot = ds;
    pc = $urandom; pmr = $urandom; evbar = $urandom & 32'h0FFF_F000; cfg = $urandom;
  endtask

  initial begin
    void'($urandom(32'd1234));
    drive(0, 0, 0, 0, 0, 0);
    {m_epc, m_eear, m_esr, m_sr, m_pmr, m_lla, m_fpc} = '0;
    repeat (3) @(negedge clk);
    chk("R11 taken", {31'd0, taken}, 32'd0);
    chk("R11 epc", epc, 32'd0);
    chk("R11 lladdr", lla, 32'd0);
    chk("R11 sr", sro, 32'd0);
    rst_n = 1;
    drive(1, 4'd12, 0, 0, 32'h0000_4006, 1); step(); // R1 R2 syscall in delay slot
    drive(1, 4'd12, 0, 0, 32'h0, 0); step();        // R1
    drive(1, 4'd7, 0, 0, 32'h0, 0); step();         // R3
    drive(1, 4'd2, 0, 0, 32'h0, 0); step();         // R3 hold
    drive(1, 4'd0, 1, 1, 32'h6, 0); step();         // R7 code 0
    drive(1, 4'd15, 0, 0, 32'h6, 1); step();        // R7 code 15
    drive(0, 0, 1, 1, 32'h6, 0); step();            // R8 both
    drive(0, 0, 1, 1, 32'h4, 0); step();            // R8 tick masked
    drive(0, 0, 1, 1, 32'h0, 0); step();            // R8 both masked
    drive(1, 4'd14, 1, 1, 32'h6, 0); step();        // R9
    drive(0, 0, 0, 0, 32'hFFFF_FFFF, 1); step();    // R10 idle hold
    for (int i = 0; i < 3000; i++) begin
      drive(($urandom % 4) == 0, 4'($urandom), $urandom % 2, $urandom % 2, $urandom, $urandom % 2);
      step();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule